// File: doc/BRIEF.md
# Checkpoint-Vote Controller for Triple Redundancy

This block coordinates three redundant copies of a logic island, each advancing on its own clock source. The controller sees one tick per replica for every local cycle that replica would run, and returns a per-replica enable that decides whether the tick actually advances the replica. Every replica runs for a fixed number of enabled ticks and then holds. Once all three are held, the controller takes a bitwise majority of their state vectors. In the next cycle it presents the result with a one-cycle load strobe so that every replica overwrites its registers. After that it releases all three enables together.

There is no per-cycle vote, because the replicas drift apart in time. The vote happens only at these rendezvous points. A replica that does not reach its rendezvous in time is excluded for that round. The vote is then formed from the replicas that did arrive, and the result is still loaded into all three, including the late one.

Top module: `tmr_ckpt_ctrl`

## Requirements
- R1: While reset is asserted and after its release, all three enables are high, and load, mismatch, failed flags and the voted vector are zero.
- R2: Each replica's enable stays high until exactly N ticks of that replica have been counted while enabled. It is low from the following cycle until the round is released.
- R3: A tick that arrives while a replica's enable is low is not counted.
- R4: In the cycle after the one in which all three replicas are held, load is high for exactly one cycle, and all enables are low during that cycle.
- R5: In the cycle after the load strobe, all three enables are high again and every tick counter starts from zero.
- R6: With all three replicas present, voted bit i is the majority of bit i of the three state vectors sampled in the decision cycle. Replica r's vector is state_i[r*W +: W].
- R7: Let at least one replica be held but not all three. If TIMEOUT such cycles have passed, counting from the first cycle with a held replica, the round is decided. During the load cycle, failed bit r is high exactly for the replicas that were not held. At all other times failed is zero.
- R8: An excluded replica's vector is replaced by the vector of the lowest-indexed held replica before the majority is taken.
- R9: Mismatch is high only in the load cycle. It is high exactly when some held replica's vector differs from the voted vector.
- R10: The voted vector changes only when load rises, and it holds its value between load strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | controller clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| tick_i | input | 3 | one local-cycle tick per replica |
| state_i | input | 3*W | concatenated replica state vectors, replica 0 lowest |
| clk_en_o | output | 3 | per-replica clock enable |
| load_o | output | 1 | one-cycle strobe to write back the voted state |
| voted_o | output | W | majority-voted state |
| mismatch_o | output | 1 | some present replica disagreed with the vote |
| failed_o | output | 3 | replicas excluded by the timeout |

## Verification
The bench runs one checkpoint round for every combination of three small state vectors, with irregular tick patterns. Ticks that arrive while a replica is held must be ignored; a counter that took them would halt its replica early or late, and the enable comparison would fail. It then blocks every nonempty proper subset of replicas, so that the timeout path and the substitution vote run for each exclusion mask. A controller that voted with a stale vector would produce a wrong voted value. One that timed out a cycle early or late would move the load strobe. One that flagged the wrong replica would produce a wrong failed mask. Mismatch is compared in every cycle, so a flag that was held too long or raised outside the load cycle is also caught.

// File: rtl/tmr_ckpt_pkg.sv
package tmr_ckpt_pkg;
  typedef enum logic {PH_RUN = 1'b0, PH_LOAD = 1'b1} phase_e;
endpackage

// File: rtl/tmr_ckpt_cnt.sv
module tmr_ckpt_cnt #(
  parameter int N = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic run_i,
  input  logic clear_i,
  output logic en_o,
  output logic halted_o
);
  localparam int CW = (N > 2) ? $clog2(N) : 1;

  logic [CW-1:0] cnt_q;
  logic          halt_q;

  assign en_o     = run_i & ~halt_q;
  assign halted_o = halt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      halt_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q  <= '0;
      halt_q <= 1'b0;
    end else if (en_o && tick_i) begin
      if (cnt_q == CW'(N - 1)) begin
        cnt_q  <= '0;
        halt_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tmr_ckpt_vote.sv
module tmr_ckpt_vote #(
  parameter int W = 8
) (
  input  logic [3*W-1:0] state_i,
  input  logic [2:0]     incl_i,
  output logic [W-1:0]   vote_o,
  output logic           diff_o
);
  logic [W-1:0] src [3];
  logic [W-1:0] sub [3];
  logic [W-1:0] pick;
  logic [2:0]   ne;

  for (genvar g = 0; g < 3; g++) begin : g_src
    assign src[g] = state_i[g*W +: W];
  end

  always_comb begin
    if (incl_i[0])      pick = src[0];
    else if (incl_i[1]) pick = src[1];
    else                pick = src[2];
  end

  for (genvar g = 0; g < 3; g++) begin : g_sub
    assign sub[g] = incl_i[g] ? src[g] : pick;
    assign ne[g]  = incl_i[g] && (src[g] != vote_o);
  end

  assign vote_o = (sub[0] & sub[1]) | (sub[0] & sub[2]) | (sub[1] & sub[2]);
  assign diff_o = |ne;
endmodule

// File: rtl/tmr_ckpt_ctrl.sv
module tmr_ckpt_ctrl
  import tmr_ckpt_pkg::*;
#(
  parameter int W       = 8,
  parameter int N       = 4,
  parameter int TIMEOUT = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [2:0]     tick_i,
  input  logic [3*W-1:0] state_i,
  output logic [2:0]     clk_en_o,
  output logic           load_o,
  output logic [W-1:0]   voted_o,
  output logic           mismatch_o,
  output logic [2:0]     failed_o
);
  localparam int TW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;

  phase_e        phase_q;
  logic [TW-1:0] tmo_q;
  logic [W-1:0]  voted_q;
  logic          mis_q;
  logic [2:0]    fail_q;
  logic [2:0]    halted, en;
  logic          run, clear, all_h, any_h, decide;
  logic [W-1:0]  vote_w;
  logic          diff_w;

  assign run   = (phase_q == PH_RUN);
  assign clear = (phase_q == PH_LOAD);

  for (genvar g = 0; g < 3; g++) begin : g_rep
    tmr_ckpt_cnt #(.N(N)) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_i[g]),
      .run_i    (run),
      .clear_i  (clear),
      .en_o     (en[g]),
      .halted_o (halted[g])
    );
  end

  tmr_ckpt_vote #(.W(W)) u_vote (
    .state_i (state_i),
    .incl_i  (halted),
    .vote_o  (vote_w),
    .diff_o  (diff_w)
  );

  assign all_h  = &halted;
  assign any_h  = |halted;
  // decide once all arrived, or when the straggler window has run out
  assign decide = run && (all_h || (any_h && tmo_q == TW'(TIMEOUT - 1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_RUN;
      tmo_q   <= '0;
      voted_q <= '0;
      mis_q   <= 1'b0;
      fail_q  <= '0;
    end else if (run) begin
      if (decide) begin
        phase_q <= PH_LOAD;
        voted_q <= vote_w;
        mis_q   <= diff_w;
        fail_q  <= ~halted;
      end else if (any_h) begin
        tmo_q <= tmo_q + 1'b1;
      end
    end else begin
      phase_q <= PH_RUN;
      tmo_q   <= '0;
      mis_q   <= 1'b0;
      fail_q  <= '0;
    end
  end

  assign clk_en_o   = en;
  assign load_o     = clear;
  assign voted_o    = voted_q;
  assign mismatch_o = mis_q;
  assign failed_o   = fail_q;
endmodule

// File: rtl/tmr_ckpt_chk.sv
module tmr_ckpt_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [2:0]   clk_en_o,
  input logic         load_o,
  input logic [W-1:0] voted_o,
  input logic         mismatch_o,
  input logic [2:0]   failed_o
);
  // R4
  load_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> (clk_en_o == 3'b000));
  // R4
  load_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o);
  // R5
  release_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> (clk_en_o == 3'b111));
  // R9
  mismatch_in_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mismatch_o |-> load_o);
  // R7
  failed_in_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (failed_o != 3'b000) |-> (load_o && failed_o != 3'b111));
  // R10
  voted_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(voted_o) |-> load_o);
endmodule

bind tmr_ckpt_ctrl tmr_ckpt_chk #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clk_en_o   (clk_en_o),
  .load_o     (load_o),
  .voted_o    (voted_o),
  .mismatch_o (mismatch_o),
  .failed_o   (failed_o)
);

// File: tb/tmr_ckpt_ctrl_bench.sv
module tmr_ckpt_ctrl_bench;
  localparam int W   = 3;
  localparam int N   = 3;
  localparam int TMO = 6;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [2:0]     tick = '0;
  logic [3*W-1:0] st = '0;
  logic [2:0]     en;
  logic           load;
  logic [W-1:0]   voted;
  logic           mis;
  logic [2:0]     failed;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // expected state
  int           m_cnt [3];
  logic [2:0]   m_halt = '0;
  logic         m_load = 1'b0;
  int           m_tmo = 0;
  logic [W-1:0] m_voted = '0;
  logic         m_mis = 1'b0;
  logic [2:0]   m_fail = '0;
  logic [15:0]  lfsr = 16'hACE1;

  always #2 clk = ~clk;

  tmr_ckpt_ctrl #(.W(W), .N(N), .TIMEOUT(TMO)) u_tmr_ckpt_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .state_i(st),
    .clk_en_o(en), .load_o(load), .voted_o(voted),
    .mismatch_o(mis), .failed_o(failed)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] ref_vote(input logic [3*W-1:0] s, input logic [2:0] inc);
    logic [W-1:0] a0, a1, a2, p;
    a0 = s[0 +: W]; a1 = s[W +: W]; a2 = s[2*W +: W];
    p = inc[0] ? a0 : (inc[1] ? a1 : a2);
    if (!inc[0]) a0 = p;
    if (!inc[1]) a1 = p;
    if (!inc[2]) a2 = p;
    return (a0 & a1) | (a0 & a2) | (a1 & a2);
  endfunction

  task automatic check_outs();
    logic [2:0] exp_en;
    exp_en = m_load ? 3'b000 : ~m_halt;
    chk("R2 R3 R5 clk_en", int'(en), int'(exp_en));
    chk("R4 load", int'(load), int'(m_load));
    chk((m_fail != 0) ? "R8 voted" : "R6 R10 voted", int'(voted), int'(m_voted));
    chk("R9 mismatch", int'(mis), int'(m_mis));
    chk("R7 failed", int'(failed), int'(m_fail));
  endtask

  // one controller cycle: drive, advance expected state, check after edge
  task automatic cyc(input logic [2:0] tk);
    logic [W-1:0] v;
    tick = tk;
    if (m_load) begin
      m_load = 0; m_halt = '0; m_tmo = 0; m_mis = 0; m_fail = '0;
      for (int r = 0; r < 3; r++) m_cnt[r] = 0;
    end else if ((&m_halt) || ((|m_halt) && m_tmo == TMO - 1)) begin
      v = ref_vote(st, m_halt);
      m_load = 1; m_voted = v; m_fail = ~m_halt;
      m_mis = 0;
      for (int r = 0; r < 3; r++)
        if (m_halt[r] && st[r*W +: W] != v) m_mis = 1;
    end else begin
      if (|m_halt) m_tmo++;
      for (int r = 0; r < 3; r++)
        if (!m_halt[r] && tk[r]) begin
          if (m_cnt[r] == N - 1) begin m_halt[r] = 1; m_cnt[r] = 0; end
          else m_cnt[r]++;
        end
    end
    @(posedge clk);
    @(negedge clk);
    check_outs();
  endtask

  task automatic round(input logic [3*W-1:0] s, input logic [2:0] blocked);
    st = s;
    while (!m_load) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[2:0] & ~blocked);
    end
    cyc(lfsr[5:3]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    for (int r = 0; r < 3; r++) m_cnt[r] = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 clk_en", int'(en), 7);
    chk("R1 load", int'(load), 0);
    chk("R1 voted", int'(voted), 0);
    chk("R1 mismatch", int'(mis), 0);
    chk("R1 failed", int'(failed), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_outs();
    // all three present: every state combination (R6, R9)
    for (int c = 0; c < (1 << (3 * W)); c++) round(c[3*W-1:0], 3'b000);
    // stragglers: every nonempty proper subset blocked (R7, R8)
    for (int m = 1; m < 7; m++)
      for (int c = 0; c < 64; c++)
        round({c[5:0], c[2:0]} ^ {3'(m), 3'(c), 3'(m)}, 3'(m));
    // ticks during hold are ignored (R3)
    round(9'o725, 3'b000);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule